// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block models the feedback divider of a frequency synthesizer in logic. A dual-modulus prescaler counts the high-speed input clock and ends each of its own cycles after either P or P+1 input clocks. P is 16 with the default parameters. Two down-counters decide which modulus the prescaler uses. The swallow counter holds the prescaler at P+1 for the first A prescaler cycles of each output period. The main counter ends the output period after B prescaler cycles. The input clock is therefore divided by N = 16·B + A.

Software or a neighbouring block drives the programmed swallow value A and main value B as plain inputs. The divider samples them only when the main counter expires, so a change written mid-period cannot produce a short or long period. It emits one single-clock pulse per output period and raises a configuration flag when the programmed pair cannot give the nominal ratio.

Top module: `psd_divider`

## Requirements
- R1: With 1 ≤ B ≤ 511, 0 ≤ A ≤ 15 and A < B, consecutive rising edges of `div_out` are exactly 16·B + A input clocks apart.
- R2: `div_out` is high for exactly one input clock per output period.
- R3: After a synchronous reset is released, `div_out` first reads high after the N-th rising edge of `clk` that follows the release, where N is computed from the A and B values applied during reset.
- R4: While `rst` is high at a rising edge, `div_out` is low after that edge, and the counters reload from the current `a_val` and `b_val`.
- R5: A change of `a_val` or `b_val` during an output period does not alter that period. The first period that starts after the change uses the new values.
- R6: `cfg_err` is 1 whenever `a_val` ≥ `b_val` or `b_val` = 0, and is 0 otherwise. It follows the inputs without a clock.
- R7: With 1 ≤ B and A ≥ B, every prescaler cycle uses modulus P+1, so the output period is 17·B input clocks.
- R8: The extremes B = 1, A = 0 (period 16) and B = 511, A = 15 (period 8191) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| a_val | input | 4 | Programmed swallow count A |
| b_val | input | 9 | Programmed main count B |
| div_out | output | 1 | One-clock pulse per output period |
| cfg_err | output | 1 | Flags A ≥ B or B = 0 |

## Verification
A wrong count in the prescaler, swallow counter or main counter shows at the port as a pulse interval that differs from 16·B + A, by one clock per miscounted prescaler cycle. The error is visible at the first pulse after the fault. The bench therefore measures every interval exactly, from reset release and between pulses. A reload that takes the inputs at the wrong moment makes the period after a mid-period change carry the wrong value, which shows within two pulses. Pulse width and the configuration flag are checked directly at the ports.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } modulus_e;

   function automatic int unsigned psd_ratio(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned p);
      if (a < b) return p * b + a;
      return (p + 1) * b;
   endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int PRE_LOG2 = 4
) (
   input  logic     clk,
   input  logic     rst,
   input  modulus_e mode,
   output logic     pre_tc
);

   localparam int PC_W = PRE_LOG2 + 1;
   localparam int P    = 1 << PRE_LOG2;
   localparam logic [PC_W-1:0] LIM_LOW  = PC_W'(P - 1);
   localparam logic [PC_W-1:0] LIM_HIGH = PC_W'(P);

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_lim;

   initial begin
      assert (PRE_LOG2 >= 2) else $error("prescaler modulus too small");
   end

   assign pc_lim = (mode == MOD_HIGH) ? LIM_HIGH : LIM_LOW;
   assign pre_tc = (pc == pc_lim);

   always_ff @(posedge clk) begin
      if (rst)         pc <= '0;
      else if (pre_tc) pc <= '0;
      else             pc <= pc + 1'b1;
   end

   // R1
   pc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      pc <= LIM_HIGH);

   // R1
   pc_restart_chk: assert property (@(posedge clk) disable iff (rst)
      pre_tc |=> (pc == '0));

endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt
   import psd_pkg::*;
#(
   parameter int ACNT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pre_tc,
   input  logic              reload,
   input  logic [ACNT_W-1:0] a_in,
   output modulus_e          mode
);

   localparam logic [ACNT_W-1:0] A_ONE = ACNT_W'(1);

   logic [ACNT_W-1:0] a_cnt;

   assign mode = (a_cnt != '0) ? MOD_HIGH : MOD_LOW;

   always_ff @(posedge clk) begin
      if (rst)                         a_cnt <= a_in;
      else if (reload)                 a_cnt <= a_in;
      else if (pre_tc && a_cnt != '0)  a_cnt <= a_cnt - A_ONE;
   end

   // R1
   swallow_step_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_tc && !reload && a_cnt != '0) |=> (a_cnt == ($past(a_cnt) - A_ONE)));

   // R5
   swallow_reload_chk: assert property (@(posedge clk) disable iff (rst)
      reload |=> (a_cnt == $past(a_in)));

   // R5
   swallow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pre_tc && !reload) |=> $stable(a_cnt));

endmodule

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
   parameter int BCNT_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pre_tc,
   input  logic [BCNT_W-1:0] b_in,
   output logic              b_last
);

   localparam logic [BCNT_W-1:0] B_ONE = BCNT_W'(1);

   logic [BCNT_W-1:0] b_cnt;

   assign b_last = (b_cnt <= B_ONE);

   always_ff @(posedge clk) begin
      if (rst)                  b_cnt <= b_in;
      else if (pre_tc) begin
         if (b_last)            b_cnt <= b_in;
         else                   b_cnt <= b_cnt - B_ONE;
      end
   end

   // R5
   main_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_tc && b_last) |=> (b_cnt == $past(b_in)));

   // R1
   main_step_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_tc && !b_last) |=> (b_cnt == ($past(b_cnt) - B_ONE)));

endmodule

// File: rtl/psd_cfg_check.sv
module psd_cfg_check #(
   parameter int ACNT_W = 4,
   parameter int BCNT_W = 9
) (
   input  logic [ACNT_W-1:0] a_in,
   input  logic [BCNT_W-1:0] b_in,
   output logic              bad_cfg
);

   logic [BCNT_W-1:0] a_wide;

   assign a_wide  = BCNT_W'(a_in);
   assign bad_cfg = (b_in == '0) || (a_wide >= b_in);

endmodule

// File: rtl/psd_divider.sv
module psd_divider
   import psd_pkg::*;
#(
   parameter int PRE_LOG2 = 4,
   parameter int ACNT_W   = 4,
   parameter int BCNT_W   = 9,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ACNT_W-1:0] a_val,
   input  logic [BCNT_W-1:0] b_val,
   output logic              div_out,
   output logic              cfg_err
);

   modulus_e mode;
   logic     pre_tc;
   logic     b_last;
   logic     reload;

   initial begin
      assert (ACNT_W <= PRE_LOG2) else $error("swallow range exceeds prescaler modulus");
      assert (BCNT_W > ACNT_W)    else $error("main counter must be wider than swallow counter");
   end

   psd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode),
      .pre_tc (pre_tc)
   );

   psd_main_cnt #(.BCNT_W(BCNT_W)) u_main (
      .clk    (clk),
      .rst    (rst),
      .pre_tc (pre_tc),
      .b_in   (b_val),
      .b_last (b_last)
   );

   assign reload = pre_tc & b_last;

   psd_swallow_cnt #(.ACNT_W(ACNT_W)) u_swl (
      .clk    (clk),
      .rst    (rst),
      .pre_tc (pre_tc),
      .reload (reload),
      .a_in   (a_val),
      .mode   (mode)
   );

   psd_cfg_check #(.ACNT_W(ACNT_W), .BCNT_W(BCNT_W)) u_cfg (
      .a_in    (a_val),
      .b_in    (b_val),
      .bad_cfg (cfg_err)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         logic div_q;
         always_ff @(posedge clk) begin
            if (rst) div_q <= 1'b0;
            else     div_q <= reload;
         end
         assign div_out = div_q;
      end else begin : g_out_comb
         assign div_out = reload & ~rst;
      end
   endgenerate

   // R2
   pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      div_out |=> !div_out);

   // R4
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!div_out || !OUT_REG));

endmodule

// File: tb/psd_divider_tb.sv
module psd_divider_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a_val = 4'd0;
   logic [8:0] b_val = 9'd1;
   logic       div_out;
   logic       cfg_err;

   int total = 0;
   int bad   = 0;
   int edges = 0;

   always #2 clk = ~clk;
   always @(posedge clk) edges++;

   psd_divider dut_i (
      .clk     (clk),
      .rst     (rst),
      .a_val   (a_val),
      .b_val   (b_val),
      .div_out (div_out),
      .cfg_err (cfg_err)
   );

   function automatic int exp_n(input int a, input int b);
      if (a < b) return 16 * b + a;
      return 17 * b;
   endfunction

   function automatic bit exp_err(input int a, input int b);
      return (b == 0) || (a >= b);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse(output int cyc);
      cyc = 0;
      forever begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (div_out || cyc > 20000) break;
      end
   endtask

   task automatic do_reset(input int a, input int b);
      @(negedge clk);
      rst = 1'b1;
      a_val = 4'(a);
      b_val = 9'(b);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R4 out low in reset", int'(div_out), 0);
      end
      rst = 1'b0;
   endtask

   task automatic period_pair_change(input int a0, input int b0, input int a1,
                                     input int b1, input int dly);
      int c;
      do_reset(a0, b0);
      wait_pulse(c);
      chk("R3 first pulse", c, exp_n(a0, b0));
      c = 0;
      for (int i = 0; i < dly; i++) begin
         @(posedge clk);
         @(negedge clk);
         c++;
      end
      a_val = 4'(a1);
      b_val = 9'(b1);
      begin
         int r;
         wait_pulse(r);
         chk("R5 running period keeps old ratio", c + r, exp_n(a0, b0));
      end
      wait_pulse(c);
      chk("R5 next period uses new ratio", c, exp_n(a1, b1));
   endtask

   initial begin : watchdog
      wait (edges > 190000);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<190000", edges);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int c;
      int ra, rb;
      int unsigned seed;
      seed = $urandom(20240611);

      // R4: reset state
      do_reset(3, 10);
      chk("R4 out low after reset", int'(div_out), 0);

      // R1 R3: basic ratio
      wait_pulse(c);
      chk("R3 first pulse at N", c, exp_n(3, 10));
      @(posedge clk); @(negedge clk);
      chk("R2 pulse one clock wide", int'(div_out), 0);
      wait_pulse(c);
      chk("R1 period after width check", c + 1, exp_n(3, 10));
      wait_pulse(c);
      chk("R1 steady period", c, exp_n(3, 10));

      // R8: extremes
      do_reset(0, 1);
      wait_pulse(c);
      chk("R8 min ratio first", c, 16);
      wait_pulse(c);
      chk("R8 min ratio period", c, 16);
      do_reset(15, 511);
      wait_pulse(c);
      chk("R8 max ratio first", c, 8191);
      wait_pulse(c);
      chk("R8 max ratio period", c, 8191);

      // R7: A >= B
      do_reset(9, 4);
      wait_pulse(c);
      chk("R7 first pulse with A>=B", c, 68);
      wait_pulse(c);
      chk("R7 period with A>=B", c, 68);

      // R5: mid-period changes
      period_pair_change(2, 5, 11, 20, 7);
      period_pair_change(14, 30, 0, 2, 0);
      period_pair_change(0, 3, 15, 16, 12);

      // R6: configuration flag
      for (int i = 0; i < 6; i++) begin
         int ta, tb;
         case (i)
            0: begin ta = 0;  tb = 0;  end
            1: begin ta = 5;  tb = 5;  end
            2: begin ta = 4;  tb = 5;  end
            3: begin ta = 15; tb = 16; end
            4: begin ta = 15; tb = 3;  end
            default: begin ta = 0; tb = 1; end
         endcase
         @(negedge clk);
         a_val = 4'(ta);
         b_val = 9'(tb);
         #1;
         chk("R6 cfg flag", int'(cfg_err), int'(exp_err(ta, tb)));
      end

      // R1 R6 R7: constrained random
      for (int k = 0; k < 20; k++) begin
         ra = int'($urandom % 16);
         if (($urandom % 4) == 0) rb = 1 + int'($urandom % 15);
         else                     rb = ra + 1 + int'($urandom % 40);
         do_reset(ra, rb);
         #1;
         chk("R6 random cfg flag", int'(cfg_err), int'(exp_err(ra, rb)));
         wait_pulse(c);
         chk("R3 random first pulse", c, exp_n(ra, rb));
         wait_pulse(c);
         chk(ra < rb ? "R1 random period" : "R7 random period", c, exp_n(ra, rb));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule